// File: doc/BRIEF.md
# Leveled Multi-Source Interrupt Handler

This block gathers 31 local interrupt sources into one prioritized request for a processor. Each source belongs to one of three kinds, fixed by parameters:

- **Level-sensitive sources** mirror their input.
- **Edge-sensitive sources** capture a rising edge and hold it until software clears it.
- **Software sources** are raised by a set write and dropped by a clear write.

Software programs three things for each source: an enable bit, a 3-bit request level, and the pending state, which is visible on a status output whatever the enable says.

The block drives a 3-bit priority code. This code is the highest level among the pending, enabled sources; 0 means no request. A master enable can force that code to 0 without disturbing any pending state. When the processor acknowledges at the level currently driven, the block returns an 8-bit vector in the same cycle. Sources 0 to 15 take their upper nibble from base register 0, and sources 16 to 30 take it from base register 1. The lower nibble is the source's position within its group. When several sources share the winning level, the highest-numbered one is vectored.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, all pending bits, enables and levels are 0, `ipl_o` is 0, and an acknowledge gets no answer.
- R2: A level-sensitive source (index 16 to 30 by default) shows on `pend_o` the value its input had at the previous clock edge, whether or not it is enabled.
- R3: An edge-sensitive source (index 8 to 15 by default) becomes pending on a 0-to-1 change of its input between two clock edges. It stays pending after the input falls. A write of 1 to its bit through the clear port removes it. A new edge in the same cycle as the clear leaves it pending.
- R4: A software source (index 0 to 7 by default) becomes pending when its bit is written as 1 through the set port. The clear port removes it. When set and clear hit the same bit in one cycle, set wins.
- R5: Set-port bits of non-software sources, and clear-port bits of level-sensitive sources, have no effect on `pend_o`.
- R6: `ipl_o` is the largest programmed level among sources that are both pending and enabled. A source with level 0, or one that is disabled, does not contribute.
- R7: With `mie` low, `ipl_o` is 0 and `pend_o` is unchanged.
- R8: `ack_ok` is 1 in the cycle that `iack` is high with `iack_lvl` equal to a non-zero `ipl_o`. `ack_vec` is then {`vbase0`, index[3:0]} for source index 0 to 15, or {`vbase1`, (index-16)[3:0]} for index 16 to 30.
- R9: Among sources pending and enabled at the winning level, the highest index is vectored.
- R10: An acknowledge at a level different from `ipl_o`, or while `ipl_o` is 0, gives `ack_ok` 0 and `ack_vec` 0.
- R11: An enable write replaces all 31 enables. A level write sets the level of the source selected by `lvl_sel`. Both act from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 31 | Raw interrupt inputs |
| en_we | input | 1 | Enable register write strobe |
| en_data | input | 31 | New enable bits |
| lvl_we | input | 1 | Level write strobe |
| lvl_sel | input | 5 | Source whose level is written |
| lvl_val | input | 3 | Level value |
| clr_we | input | 1 | Clear write strobe |
| clr_data | input | 31 | Bits to clear (1 = clear) |
| swi_we | input | 1 | Software set write strobe |
| swi_data | input | 31 | Bits to set (1 = set) |
| vbase0 | input | 4 | Vector upper nibble, group 0 |
| vbase1 | input | 4 | Vector upper nibble, group 1 |
| mie | input | 1 | Master interrupt enable |
| iack | input | 1 | Interrupt acknowledge |
| iack_lvl | input | 3 | Level being acknowledged |
| pend_o | output | 31 | Pending status, unmasked |
| ipl_o | output | 3 | Priority code to processor |
| ack_ok | output | 1 | Acknowledge answered |
| ack_vec | output | 8 | Returned vector |

## Verification
The hardest situation to reach is a tie at the top level between sources of different kinds and groups. One case is an edge-latched source in group 0 sharing a level with a level-sensitive source in group 1, while a disabled source sits pending at a higher level. The stimulus programs these levels first. It pulses the edge input and keeps the level input high, then drops the level input so the winner passes to the other group. Clear and set are applied in the same cycle as a fresh edge or a set, to probe which one takes precedence.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
    localparam int NSRC_D = 31;
    localparam int LVLW_D = 3;
    localparam int IDXW_D = 4;
    localparam int BASEW_D = 4;

    typedef enum logic [1:0] {
        KIND_LEVEL = 2'd0,
        KIND_EDGE  = 2'd1,
        KIND_SOFT  = 2'd2
    } src_kind_e;

    typedef struct packed {
        logic       hit;
        logic [4:0] idx;
        logic [2:0] lvl;
    } win_t;

    function automatic src_kind_e kind_of(input int i, input logic [63:0] soft_m,
                                          input logic [63:0] edge_m);
        if (soft_m[i])      return KIND_SOFT;
        else if (edge_m[i]) return KIND_EDGE;
        else                return KIND_LEVEL;
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_level_pkg::*;
#(
    parameter int NSRC = NSRC_D,
    parameter logic [NSRC-1:0] SWI_MASK = '0,
    parameter logic [NSRC-1:0] EDGE_MASK = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] clr_bits,
    input  logic [NSRC-1:0] set_bits,
    output logic [NSRC-1:0] pend
);
    logic [NSRC-1:0] nxt;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam src_kind_e K = kind_of(g, 64'(SWI_MASK), 64'(EDGE_MASK));
        if (K == KIND_SOFT) begin : g_soft
            assign nxt[g] = (pend[g] & ~clr_bits[g]) | set_bits[g];
        end else if (K == KIND_EDGE) begin : g_edge
            logic prev;
            always_ff @(posedge clk) begin
                if (rst) prev <= 1'b0;
                else     prev <= src_in[g];
            end
            assign nxt[g] = (pend[g] & ~clr_bits[g]) | (src_in[g] & ~prev);
        end else begin : g_lvl
            assign nxt[g] = src_in[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= nxt;
    end
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
    import irq_level_pkg::*;
#(
    parameter int NSRC = NSRC_D,
    parameter int LVLW = LVLW_D,
    localparam int SELW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]           pend,
    input  logic [NSRC-1:0]           en,
    input  logic [NSRC-1:0][LVLW-1:0] lvl,
    input  logic                      mie,
    output logic [LVLW-1:0]           top_lvl,
    output logic [SELW-1:0]           top_idx
);
    always_comb begin
        top_lvl = '0;
        top_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && en[i] && lvl[i] != '0 && lvl[i] >= top_lvl) begin
                top_lvl = lvl[i];
                top_idx = SELW'(i);
            end
        end
        if (!mie) top_lvl = '0;
    end
endmodule

// File: rtl/irq_vector.sv
module irq_vector
    import irq_level_pkg::*;
#(
    parameter int LVLW = LVLW_D,
    parameter int SELW = 5,
    parameter int IDXW = IDXW_D,
    parameter int BASEW = BASEW_D,
    localparam int VECW = BASEW + IDXW
) (
    input  logic [SELW-1:0]  top_idx,
    input  logic [LVLW-1:0]  top_lvl,
    input  logic             iack,
    input  logic [LVLW-1:0]  iack_lvl,
    input  logic [BASEW-1:0] base0,
    input  logic [BASEW-1:0] base1,
    output logic             ok,
    output logic [VECW-1:0]  vec
);
    logic grp1;
    assign grp1 = |top_idx[SELW-1:IDXW];

    always_comb begin
        ok  = iack && (top_lvl != '0) && (iack_lvl == top_lvl);
        vec = '0;
        if (ok) vec = {grp1 ? base1 : base0, top_idx[IDXW-1:0]};
    end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_level_pkg::*;
#(
    parameter int NSRC = NSRC_D,
    parameter int LVLW = LVLW_D,
    parameter int IDXW = IDXW_D,
    parameter int BASEW = BASEW_D,
    parameter logic [NSRC-1:0] SWI_MASK = NSRC'(32'h0000_00FF),
    parameter logic [NSRC-1:0] EDGE_MASK = NSRC'(32'h0000_FF00),
    localparam int SELW = $clog2(NSRC),
    localparam int VECW = BASEW + IDXW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_in,
    input  logic             en_we,
    input  logic [NSRC-1:0]  en_data,
    input  logic             lvl_we,
    input  logic [SELW-1:0]  lvl_sel,
    input  logic [LVLW-1:0]  lvl_val,
    input  logic             clr_we,
    input  logic [NSRC-1:0]  clr_data,
    input  logic             swi_we,
    input  logic [NSRC-1:0]  swi_data,
    input  logic [BASEW-1:0] vbase0,
    input  logic [BASEW-1:0] vbase1,
    input  logic             mie,
    input  logic             iack,
    input  logic [LVLW-1:0]  iack_lvl,
    output logic [NSRC-1:0]  pend_o,
    output logic [LVLW-1:0]  ipl_o,
    output logic             ack_ok,
    output logic [VECW-1:0]  ack_vec
);
    logic [NSRC-1:0]           en_q;
    logic [NSRC-1:0][LVLW-1:0] lvl_q;
    logic [NSRC-1:0]           clr_bits, set_bits;
    logic [SELW-1:0]           top_idx;

    assign clr_bits = clr_we ? clr_data : '0;
    assign set_bits = swi_we ? swi_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (en_we) en_q <= en_data;
            if (lvl_we && 32'(lvl_sel) < NSRC) lvl_q[lvl_sel] <= lvl_val;
        end
    end

    irq_pend_bank #(.NSRC(NSRC), .SWI_MASK(SWI_MASK), .EDGE_MASK(EDGE_MASK)) u_bank (
        .clk(clk), .rst(rst), .src_in(src_in),
        .clr_bits(clr_bits), .set_bits(set_bits), .pend(pend_o)
    );

    irq_resolve #(.NSRC(NSRC), .LVLW(LVLW)) u_res (
        .pend(pend_o), .en(en_q), .lvl(lvl_q), .mie(mie),
        .top_lvl(ipl_o), .top_idx(top_idx)
    );

    irq_vector #(.LVLW(LVLW), .SELW(SELW), .IDXW(IDXW), .BASEW(BASEW)) u_vec (
        .top_idx(top_idx), .top_lvl(ipl_o), .iack(iack), .iack_lvl(iack_lvl),
        .base0(vbase0), .base1(vbase1), .ok(ack_ok), .vec(ack_vec)
    );
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
    parameter int NSRC = 31,
    parameter int LVLW = 3,
    parameter int BASEW = 4,
    parameter int VECW = 8,
    parameter logic [NSRC-1:0] SWI_MASK = '0,
    parameter logic [NSRC-1:0] EDGE_MASK = '0
) (
    input logic             clk,
    input logic             rst,
    input logic [NSRC-1:0]  src_in,
    input logic             clr_we,
    input logic [NSRC-1:0]  clr_data,
    input logic             swi_we,
    input logic [NSRC-1:0]  swi_data,
    input logic [BASEW-1:0] vbase0,
    input logic [BASEW-1:0] vbase1,
    input logic             mie,
    input logic             iack,
    input logic [LVLW-1:0]  iack_lvl,
    input logic [NSRC-1:0]  pend_o,
    input logic [LVLW-1:0]  ipl_o,
    input logic             ack_ok,
    input logic [VECW-1:0]  ack_vec
);
    localparam logic [NSRC-1:0] LVL_MASK = ~(SWI_MASK | EDGE_MASK);
    logic [NSRC-1:0] edge_keep;
    assign edge_keep = pend_o & EDGE_MASK & ~(clr_we ? clr_data : '0);

    // R2
    a_r2_level_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend_o & LVL_MASK) == ($past(src_in) & LVL_MASK));
    // R3
    a_r3_edge_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend_o & $past(edge_keep)) == $past(edge_keep));
    // R4
    a_r4_soft_set: assert property (@(posedge clk) disable iff (rst)
        swi_we |=> (pend_o & $past(swi_data & SWI_MASK)) == $past(swi_data & SWI_MASK));
    // R7
    a_r7_mie_gate: assert property (@(posedge clk) disable iff (rst)
        !mie |-> ipl_o == '0);
    // R10
    a_r10_ack_match: assert property (@(posedge clk) disable iff (rst)
        ack_ok |-> (iack && ipl_o != '0 && iack_lvl == ipl_o));
    // R8
    a_r8_vec_base: assert property (@(posedge clk) disable iff (rst)
        ack_ok |-> (ack_vec[VECW-1:VECW-BASEW] == vbase0 ||
                    ack_vec[VECW-1:VECW-BASEW] == vbase1));
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
    .NSRC(NSRC), .LVLW(LVLW), .BASEW(BASEW), .VECW(VECW),
    .SWI_MASK(SWI_MASK), .EDGE_MASK(EDGE_MASK)
) u_chk (.*);

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [30:0] src_in = '0, en_data = '0, clr_data = '0, swi_data = '0;
    logic        en_we = 0, lvl_we = 0, clr_we = 0, swi_we = 0;
    logic [4:0]  lvl_sel = '0;
    logic [2:0]  lvl_val = '0, iack_lvl = '0;
    logic [3:0]  vbase0 = 4'hA, vbase1 = 4'h5;
    logic        mie = 1'b1, iack = 1'b0;
    logic [30:0] pend_o;
    logic [2:0]  ipl_o;
    logic        ack_ok;
    logic [7:0]  ack_vec;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    bit  m_pend [31];
    bit  m_en   [31];
    int  m_lvl  [31];
    bit  m_prev [31];

    always #10 clk = ~clk;

    irq_level_ctrl uut (
        .clk(clk), .rst(rst), .src_in(src_in), .en_we(en_we), .en_data(en_data),
        .lvl_we(lvl_we), .lvl_sel(lvl_sel), .lvl_val(lvl_val),
        .clr_we(clr_we), .clr_data(clr_data), .swi_we(swi_we), .swi_data(swi_data),
        .vbase0(vbase0), .vbase1(vbase1), .mie(mie), .iack(iack), .iack_lvl(iack_lvl),
        .pend_o(pend_o), .ipl_o(ipl_o), .ack_ok(ack_ok), .ack_vec(ack_vec)
    );

    function automatic int kind(int i); // 0 level, 1 edge, 2 soft
        if (i < 8) return 2;
        if (i < 16) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < 31; i++) begin
            if (rst) begin
                m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; m_prev[i] = 0;
            end else begin
                bit c, s;
                c = clr_we && clr_data[i];
                s = swi_we && swi_data[i];
                case (kind(i))
                    2: m_pend[i] = s ? 1'b1 : (c ? 1'b0 : m_pend[i]);
                    1: begin
                        m_pend[i] = (src_in[i] && !m_prev[i]) ? 1'b1 : (c ? 1'b0 : m_pend[i]);
                        m_prev[i] = src_in[i];
                    end
                    default: m_pend[i] = src_in[i];
                endcase
                if (en_we) m_en[i] = en_data[i];
                if (lvl_we && int'(lvl_sel) == i) m_lvl[i] = int'(lvl_val);
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, just before each rising edge
    initial forever begin
        @(negedge clk); #9;
        if (!rst && !done) begin
            int best, widx;
            logic [30:0] ep;
            logic [7:0] ev;
            bit eok;
            best = 0; widx = 0;
            for (int i = 0; i < 31; i++) begin
                ep[i] = m_pend[i];
                if (m_pend[i] && m_en[i] && m_lvl[i] != 0 && m_lvl[i] >= best) begin
                    best = m_lvl[i]; widx = i;
                end
            end
            if (!mie) best = 0;
            eok = iack && best != 0 && int'(iack_lvl) == best;
            ev = !eok ? 8'h00 : (widx < 16 ? {vbase0, 4'(widx)} : {vbase1, 4'(widx - 16)});
            chk(32'(pend_o), 32'(ep), "R2/R3/R4/R5 model pend");
            chk(32'(ipl_o), 32'(best), "R6/R7 model ipl");
            chk({23'd0, ack_ok, ack_vec}, {23'd0, eok, ev}, "R8/R9/R10 model ack");
        end
    end

    task automatic cyc();
        @(negedge clk); #2;
    endtask

    task automatic set_lvl(input int i, input int v);
        lvl_we = 1; lvl_sel = 5'(i); lvl_val = 3'(v);
        cyc();
        lvl_we = 0;
    endtask

    task automatic probe_ack(input int lv, input logic ok_e, input logic [7:0] v_e,
                             input string tag);
        iack = 1; iack_lvl = 3'(lv);
        #1;
        chk({31'd0, ack_ok}, {31'd0, ok_e}, tag);
        chk(32'(ack_vec), 32'(v_e), tag);
        iack = 0; iack_lvl = 0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(); cyc(); cyc();
        rst = 0;
        cyc();
        // R1
        chk(32'(pend_o), 0, "R1 pend after reset");
        chk(32'(ipl_o), 0, "R1 ipl after reset");
        probe_ack(0, 1'b0, 8'h00, "R1 no answer after reset");

        set_lvl(20, 5); set_lvl(10, 5); set_lvl(3, 2);
        set_lvl(30, 7); set_lvl(12, 1); set_lvl(25, 5);
        en_we = 1; en_data = 31'h3FFF_FFFF; cyc(); en_we = 0;

        src_in[20] = 1; cyc();
        chk(32'(pend_o), 32'h0010_0000, "R2 level source follows input");
        chk(32'(ipl_o), 5, "R6 level of single source");
        probe_ack(5, 1'b1, 8'h54, "R8 group 1 vector");

        src_in[30] = 1; cyc();
        chk(32'(pend_o[30]), 1, "R6 status independent of enable");
        chk(32'(ipl_o), 5, "R6 disabled source ignored");

        src_in[10] = 1; cyc(); src_in[10] = 0; cyc();
        chk(32'(pend_o[10]), 1, "R3 edge held after input falls");
        probe_ack(5, 1'b1, 8'h54, "R9 higher index wins tie");

        src_in[20] = 0; cyc();
        probe_ack(5, 1'b1, 8'hAA, "R8 group 0 vector");
        probe_ack(4, 1'b0, 8'h00, "R10 mismatched level ignored");

        mie = 0; #1;
        chk(32'(ipl_o), 0, "R7 master enable gates ipl");
        chk(32'(pend_o[10]), 1, "R7 pending kept while gated");
        cyc(); mie = 1;

        clr_we = 1; clr_data = (31'd1 << 10) | (31'd1 << 30); cyc(); clr_we = 0;
        chk(32'(pend_o[10]), 0, "R3 clear removes edge");
        chk(32'(pend_o[30]), 1, "R5 clear ignored for level source");
        chk(32'(ipl_o), 0, "R6 nothing enabled pending");

        swi_we = 1; swi_data = (31'd1 << 3) | (31'd1 << 20) | (31'd1 << 12); cyc(); swi_we = 0;
        chk(32'(pend_o[3]), 1, "R4 software set");
        chk(32'(pend_o[20]), 0, "R5 set ignored for level source");
        chk(32'(pend_o[12]), 0, "R5 set ignored for edge source");
        chk(32'(ipl_o), 2, "R6 software source level");

        clr_we = 1; clr_data = 31'd1 << 3; cyc(); clr_we = 0;
        chk(32'(pend_o[3]), 0, "R4 clear removes software source");
        clr_we = 1; swi_we = 1; swi_data = 31'd1 << 3; cyc(); clr_we = 0; swi_we = 0;
        chk(32'(pend_o[3]), 1, "R4 set wins over clear");

        en_we = 1; en_data = '1; cyc(); en_we = 0;
        chk(32'(ipl_o), 7, "R11 enable write takes effect");
        probe_ack(7, 1'b1, 8'h5E, "R8 top source vector");

        set_lvl(30, 0);
        chk(32'(ipl_o), 2, "R11 level write takes effect");

        src_in[12] = 1; clr_we = 1; clr_data = 31'd1 << 12; cyc(); clr_we = 0;
        chk(32'(pend_o[12]), 1, "R3 new edge beats clear");
        chk(32'(ipl_o), 2, "R6 lower level does not win");
        cyc(); cyc();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule